// File: doc/BRIEF.md
# Bus-Watching Debug Trigger Unit

This block sits beside a processor core and watches its instruction bus and its data bus on every clock. Each of its triggers is configured to observe one of the two buses and to test one or more qualifiers on each valid transfer. On the instruction bus the qualifiers are the address and the arm state. On the data bus they are the address, the data value, the read or write direction and the arm state. All enabled qualifiers of a trigger must hold at once. When a trigger matches, it performs one configured action: request a halt, pulse trace start, pulse trace stop, or arm its partner trigger.

A trigger that needs arming is a two-stage trigger. It stays silent until its partner has already matched with the arm action. Address and data qualifiers on the data bus can be exact compares or inclusive ranges. A plain register write port loads the configuration. The halt request stays asserted until the debug side acknowledges it.

Top module: `dbg_trig_unit`

## Requirements
- R1: While rst_ni is low, halt_o, trace_start_o and trace_stop_o are low. Reset leaves every trigger disabled (control word 0) and every arm flag clear.
- R2: An enabled instruction-bus trigger with the address qualifier on asserts halt_o in the cycle after a transfer with ibus_valid_i high and ibus_addr_i equal to its low-address register.
- R3: On a data-bus trigger, all enabled qualifiers must hold on the same valid transfer. The qualifiers are: address, data, read-only (dbus_we_i = 0) and write-only (dbus_we_i = 1). If any enabled qualifier fails, the transfer produces no action.
- R4: An instruction-bus trigger ignores its data, read, write and range bits. Its outcome depends only on the enable, address and arm qualifiers.
- R5: On a data-bus trigger, a set range bit replaces the exact compare of that field with an inclusive test low <= value <= high. The range bit applies to the address and to the data independently.
- R6: A trigger whose enable bit is clear never acts. No trigger acts on a cycle where the valid signal of its selected bus is low.
- R7: halt_o stays high until halt_ack_i is sampled high. If a halt match and halt_ack_i arrive in the same cycle, halt_o stays high.
- R8: Action code 2 produces a trace_start_o pulse and action code 3 produces a trace_stop_o pulse. Each pulse lasts one cycle and appears in the cycle after the match. Action code 1 is halt, and codes 0, 5, 6 and 7 do nothing.
- R9: Action code 4 sets the arm flag of the partner trigger, which is trigger (k+1) mod NUM_TRIG. A trigger with its arm-needed bit set fires only if its arm flag was already set before the current cycle. The flag stays set until its own control word is written or reset is applied.
- R10: A configuration write uses cfg_addr_i = {trigger index, 3-bit offset}. The offsets are: 0 control, 1 address low, 2 address high, 3 data low, 4 data high. Control bits are: 0 enable, 1 bus select (1 = data bus), 2 address qualifier, 3 address range, 4 data qualifier, 5 data range, 6 read only, 7 write only, 8 arm needed, 11:9 action code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | TIDX_W+3 | Trigger index and register offset |
| cfg_wdata_i | input | WD_W | Configuration write data |
| ibus_valid_i | input | 1 | Instruction transfer valid |
| ibus_addr_i | input | ADDR_W | Instruction address |
| dbus_valid_i | input | 1 | Data transfer valid |
| dbus_addr_i | input | ADDR_W | Data address |
| dbus_data_i | input | DATA_W | Data value |
| dbus_we_i | input | 1 | Data transfer direction, 1 = write |
| halt_ack_i | input | 1 | Debug side acknowledges the halt |
| halt_o | output | 1 | Halt request level |
| trace_start_o | output | 1 | Trace start pulse |
| trace_stop_o | output | 1 | Trace stop pulse |

## Verification
The assertions check these properties on every cycle:
- outputs stay quiet during reset;
- halt_o persists until it is acknowledged, and drops after an acknowledge with no new match;
- every rising output edge has a match behind it;
- a disabled trigger never reports a match;
- an unarmed two-stage trigger never reports a match;
- arm flags never clear without a control write.

Only the bench scenarios can show that the right compare is applied. These cover exact versus inclusive range bounds, the AND of direction with address and data, qualifiers ignored on the instruction bus, and the one-cycle delay before a freshly set arm flag takes effect.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

  typedef enum logic [2:0] {
    ACT_NONE   = 3'd0,
    ACT_HALT   = 3'd1,
    ACT_TSTART = 3'd2,
    ACT_TSTOP  = 3'd3,
    ACT_ARM    = 3'd4
  } act_e;

  // bit 0 is en, bit 11:9 is act
  typedef struct packed {
    act_e act;
    logic arm_need;
    logic wr_only;
    logic rd_only;
    logic data_rng;
    logic data_en;
    logic addr_rng;
    logic addr_en;
    logic bus_dat;
    logic en;
  } ctrl_t;

  localparam int CTRL_W = 12;

  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_ALO  = 3'd1;
  localparam logic [2:0] OFS_AHI  = 3'd2;
  localparam logic [2:0] OFS_DLO  = 3'd3;
  localparam logic [2:0] OFS_DHI  = 3'd4;

endpackage

// File: rtl/dbg_trig_cfg.sv
module dbg_trig_cfg
  import dbg_trig_pkg::*;
#(
  parameter int NT     = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int WD_W   = 32,
  parameter int TIDX_W = 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         we_i,
  input  logic [TIDX_W+2:0]            addr_i,
  input  logic [WD_W-1:0]              wdata_i,
  output ctrl_t [NT-1:0]               ctrl_o,
  output logic  [NT-1:0][ADDR_W-1:0]   alo_o,
  output logic  [NT-1:0][ADDR_W-1:0]   ahi_o,
  output logic  [NT-1:0][DATA_W-1:0]   dlo_o,
  output logic  [NT-1:0][DATA_W-1:0]   dhi_o,
  output logic  [NT-1:0]               ctrl_wr_o
);

  logic [2:0] ofs;
  assign ofs = addr_i[2:0];

  for (genvar k = 0; k < NT; k++) begin : g_trig
    logic sel;
    assign sel          = we_i && (addr_i[TIDX_W+2:3] == TIDX_W'(k));
    assign ctrl_wr_o[k] = sel && (ofs == OFS_CTRL);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctrl_o[k] <= '0;
        alo_o[k]  <= '0;
        ahi_o[k]  <= '0;
        dlo_o[k]  <= '0;
        dhi_o[k]  <= '0;
      end else if (sel) begin
        case (ofs)
          OFS_CTRL: ctrl_o[k] <= ctrl_t'(wdata_i[CTRL_W-1:0]);
          OFS_ALO:  alo_o[k]  <= wdata_i[ADDR_W-1:0];
          OFS_AHI:  ahi_o[k]  <= wdata_i[ADDR_W-1:0];
          OFS_DLO:  dlo_o[k]  <= wdata_i[DATA_W-1:0];
          OFS_DHI:  dhi_o[k]  <= wdata_i[DATA_W-1:0];
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/dbg_trig_match.sv
module dbg_trig_match
  import dbg_trig_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  ctrl_t              ctrl_i,
  input  logic [ADDR_W-1:0]  alo_i,
  input  logic [ADDR_W-1:0]  ahi_i,
  input  logic [DATA_W-1:0]  dlo_i,
  input  logic [DATA_W-1:0]  dhi_i,
  input  logic               armed_i,
  input  logic               ibus_valid_i,
  input  logic [ADDR_W-1:0]  ibus_addr_i,
  input  logic               dbus_valid_i,
  input  logic [ADDR_W-1:0]  dbus_addr_i,
  input  logic [DATA_W-1:0]  dbus_data_i,
  input  logic               dbus_we_i,
  output logic               fire_o
);

  logic              dsel, valid, a_ok, d_ok, rw_ok, arm_ok;
  logic [ADDR_W-1:0] addr;

  assign dsel  = ctrl_i.bus_dat;
  assign valid = dsel ? dbus_valid_i : ibus_valid_i;
  assign addr  = dsel ? dbus_addr_i  : ibus_addr_i;

  // ranges only on the data bus
  always_comb begin
    if (!ctrl_i.addr_en)              a_ok = 1'b1;
    else if (dsel && ctrl_i.addr_rng) a_ok = (addr >= alo_i) && (addr <= ahi_i);
    else                              a_ok = (addr == alo_i);

    if (!dsel || !ctrl_i.data_en) d_ok = 1'b1;
    else if (ctrl_i.data_rng)     d_ok = (dbus_data_i >= dlo_i) && (dbus_data_i <= dhi_i);
    else                          d_ok = (dbus_data_i == dlo_i);
  end

  assign rw_ok  = !dsel || ((!ctrl_i.rd_only || !dbus_we_i) && (!ctrl_i.wr_only || dbus_we_i));
  assign arm_ok = !ctrl_i.arm_need || armed_i;
  assign fire_o = ctrl_i.en && valid && a_ok && d_ok && rw_ok && arm_ok;

endmodule

// File: rtl/dbg_trig_action.sv
module dbg_trig_action
  import dbg_trig_pkg::*;
#(
  parameter int NT = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NT-1:0]  fire_i,
  input  ctrl_t [NT-1:0] ctrl_i,
  input  logic [NT-1:0]  ctrl_wr_i,
  input  logic           halt_ack_i,
  output logic           halt_o,
  output logic           trace_start_o,
  output logic           trace_stop_o,
  output logic [NT-1:0]  armed_o
);

  logic          halt_req, start_req, stop_req;
  logic [NT-1:0] arm_set;

  always_comb begin
    halt_req  = 1'b0;
    start_req = 1'b0;
    stop_req  = 1'b0;
    arm_set   = '0;
    for (int k = 0; k < NT; k++) begin
      if (fire_i[k]) begin
        case (ctrl_i[k].act)
          ACT_HALT:   halt_req  = 1'b1;
          ACT_TSTART: start_req = 1'b1;
          ACT_TSTOP:  stop_req  = 1'b1;
          ACT_ARM:    arm_set[(k + 1) % NT] = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      halt_o        <= 1'b0;
      trace_start_o <= 1'b0;
      trace_stop_o  <= 1'b0;
      armed_o       <= '0;
    end else begin
      if (halt_req)        halt_o <= 1'b1;
      else if (halt_ack_i) halt_o <= 1'b0;
      trace_start_o <= start_req;
      trace_stop_o  <= stop_req;
      armed_o       <= (armed_o & ~ctrl_wr_i) | arm_set;
    end
  end

endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int NUM_TRIG = 2,
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  localparam int TIDX_W  = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1,
  localparam int WD_W    = (ADDR_W > DATA_W) ? ADDR_W : DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [TIDX_W+2:0] cfg_addr_i,
  input  logic [WD_W-1:0]   cfg_wdata_i,
  input  logic              ibus_valid_i,
  input  logic [ADDR_W-1:0] ibus_addr_i,
  input  logic              dbus_valid_i,
  input  logic [ADDR_W-1:0] dbus_addr_i,
  input  logic [DATA_W-1:0] dbus_data_i,
  input  logic              dbus_we_i,
  input  logic              halt_ack_i,
  output logic              halt_o,
  output logic              trace_start_o,
  output logic              trace_stop_o
);

  ctrl_t [NUM_TRIG-1:0]             ctrl;
  logic  [NUM_TRIG-1:0][ADDR_W-1:0] alo, ahi;
  logic  [NUM_TRIG-1:0][DATA_W-1:0] dlo, dhi;
  logic  [NUM_TRIG-1:0]             ctrl_wr, fire, armed, trig_en, trig_need;

  dbg_trig_cfg #(
    .NT(NUM_TRIG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WD_W(WD_W), .TIDX_W(TIDX_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .ctrl_o(ctrl), .alo_o(alo), .ahi_o(ahi), .dlo_o(dlo), .dhi_o(dhi),
    .ctrl_wr_o(ctrl_wr)
  );

  for (genvar k = 0; k < NUM_TRIG; k++) begin : g_match
    assign trig_en[k]   = ctrl[k].en;
    assign trig_need[k] = ctrl[k].arm_need;

    dbg_trig_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
      .ctrl_i(ctrl[k]), .alo_i(alo[k]), .ahi_i(ahi[k]), .dlo_i(dlo[k]), .dhi_i(dhi[k]),
      .armed_i(armed[k]),
      .ibus_valid_i, .ibus_addr_i,
      .dbus_valid_i, .dbus_addr_i, .dbus_data_i, .dbus_we_i,
      .fire_o(fire[k])
    );
  end

  dbg_trig_action #(.NT(NUM_TRIG)) u_act (
    .clk_i, .rst_ni,
    .fire_i(fire), .ctrl_i(ctrl), .ctrl_wr_i(ctrl_wr), .halt_ack_i,
    .halt_o, .trace_start_o, .trace_stop_o, .armed_o(armed)
  );

endmodule

// File: rtl/dbg_trig_chk.sv
module dbg_trig_chk #(
  parameter int NT = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          halt_ack_i,
  input logic          halt_o,
  input logic          trace_start_o,
  input logic          trace_stop_o,
  input logic [NT-1:0] fire_i,
  input logic [NT-1:0] en_i,
  input logic [NT-1:0] need_i,
  input logic [NT-1:0] armed_i,
  input logic [NT-1:0] clr_i
);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_quiet: assert (!halt_o && !trace_start_o && !trace_stop_o)
        else $error("R1 outputs active in reset");
    end
  end

  a_r7_halt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && !halt_ack_i |=> halt_o);

  a_r7_halt_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o && halt_ack_i && (fire_i == '0) |=> !halt_o);

  a_r7_halt_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(halt_o) |-> $past(fire_i != '0));

  a_r8_start_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_start_o |-> $past(fire_i != '0));

  a_r8_stop_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trace_stop_o |-> $past(fire_i != '0));

  a_r6_disabled_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i & ~en_i) == '0);

  a_r9_needs_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire_i & need_i & ~armed_i) == '0);

  a_r9_arm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((armed_i & $past(armed_i & ~clr_i)) == $past(armed_i & ~clr_i)));

endmodule

bind dbg_trig_unit dbg_trig_chk #(.NT(NUM_TRIG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .halt_ack_i(halt_ack_i),
  .halt_o(halt_o), .trace_start_o(trace_start_o), .trace_stop_o(trace_stop_o),
  .fire_i(fire), .en_i(trig_en), .need_i(trig_need), .armed_i(armed), .clr_i(ctrl_wr)
);

// File: tb/tb_dbg_trig_unit.sv
`timescale 1ns/1ps
module tb_dbg_trig_unit;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_addr_i = '0;
  logic [31:0] cfg_wdata_i = '0;
  logic        ibus_valid_i = 1'b0;
  logic [31:0] ibus_addr_i = '0;
  logic        dbus_valid_i = 1'b0;
  logic [31:0] dbus_addr_i = '0;
  logic [31:0] dbus_data_i = '0;
  logic        dbus_we_i = 1'b0;
  logic        halt_ack_i = 1'b0;
  logic        halt_o, trace_start_o, trace_stop_o;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  dbg_trig_unit dut (
    .clk_i(clk), .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .ibus_valid_i, .ibus_addr_i, .dbus_valid_i, .dbus_addr_i, .dbus_data_i, .dbus_we_i,
    .halt_ack_i, .halt_o, .trace_start_o, .trace_stop_o
  );

  // reference state
  logic [11:0] m_ctrl [2];
  logic [31:0] m_alo [2], m_ahi [2], m_dlo [2], m_dhi [2];
  int m_arm [2];
  int m_halt = 0, m_ts = 0, m_tp = 0;

  initial for (int t = 0; t < 2; t++) begin
    m_ctrl[t] = '0; m_alo[t] = '0; m_ahi[t] = '0; m_dlo[t] = '0; m_dhi[t] = '0; m_arm[t] = 0;
  end

  task automatic chk(input int ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int in_rng(logic [31:0] v, logic [31:0] lo, logic [31:0] hi);
    return (v >= lo && v <= hi) ? 1 : 0;
  endfunction

  task automatic model_step();
    int hit [2];
    int nh = 0, ns = 0, np = 0;
    int set [2];
    set[0] = 0; set[1] = 0;
    for (int t = 0; t < 2; t++) begin
      logic [11:0] c = m_ctrl[t];
      int dsel = c[1];
      logic [31:0] a = dsel ? dbus_addr_i : ibus_addr_i;
      int ok = c[0] && (dsel ? dbus_valid_i : ibus_valid_i);
      if (c[2]) ok = ok && ((dsel && c[3]) ? in_rng(a, m_alo[t], m_ahi[t]) : (a == m_alo[t]));
      if (dsel) begin
        if (c[4]) ok = ok && (c[5] ? in_rng(dbus_data_i, m_dlo[t], m_dhi[t]) : (dbus_data_i == m_dlo[t]));
        if (c[6]) ok = ok && !dbus_we_i;
        if (c[7]) ok = ok && dbus_we_i;
      end
      if (c[8]) ok = ok && m_arm[t];
      hit[t] = ok;
      if (ok) case (int'(c[11:9]))
        1: nh = 1;
        2: ns = 1;
        3: np = 1;
        4: set[(t + 1) % 2] = 1;
        default: ;
      endcase
    end
    if (nh) m_halt = 1; else if (halt_ack_i) m_halt = 0;
    m_ts = ns; m_tp = np;
    for (int t = 0; t < 2; t++) begin
      if (cfg_we_i && cfg_addr_i[3] == t[0] && cfg_addr_i[2:0] == 3'd0) m_arm[t] = 0;
      if (set[t]) m_arm[t] = 1;
    end
    if (cfg_we_i) begin
      int t = cfg_addr_i[3];
      case (cfg_addr_i[2:0])
        3'd0: m_ctrl[t] = cfg_wdata_i[11:0];
        3'd1: m_alo[t] = cfg_wdata_i;
        3'd2: m_ahi[t] = cfg_wdata_i;
        3'd3: m_dlo[t] = cfg_wdata_i;
        3'd4: m_dhi[t] = cfg_wdata_i;
        default: ;
      endcase
    end
  endtask

  // inputs already driven just after a falling edge
  task automatic cyc();
    model_step();
    @(negedge clk);
    chk(halt_o == m_halt, "R7 model halt_o", halt_o, m_halt);
    chk(trace_start_o == m_ts, "R8 model trace_start_o", trace_start_o, m_ts);
    chk(trace_stop_o == m_tp, "R8 model trace_stop_o", trace_stop_o, m_tp);
  endtask

  task automatic idle();
    cfg_we_i = 0; ibus_valid_i = 0; dbus_valid_i = 0; halt_ack_i = 0; dbus_we_i = 0;
  endtask

  task automatic wr(input int t, input int ofs, input logic [31:0] d);
    idle();
    cfg_we_i = 1; cfg_addr_i = {t[0], ofs[2:0]}; cfg_wdata_i = d;
    cyc();
    idle();
  endtask

  task automatic ib(input logic [31:0] a, input int v);
    idle(); ibus_valid_i = v[0]; ibus_addr_i = a; cyc(); idle();
  endtask

  task automatic db(input logic [31:0] a, input logic [31:0] d, input int we);
    idle(); dbus_valid_i = 1; dbus_addr_i = a; dbus_data_i = d; dbus_we_i = we[0]; cyc(); idle();
  endtask

  task automatic ack();
    idle(); halt_ack_i = 1; cyc(); idle();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    chk(!halt_o && !trace_start_o && !trace_stop_o, "R1 outputs in reset",
        {halt_o, trace_start_o, trace_stop_o}, 0);
    rst_ni = 1;
    ib(32'h0, 1);
    chk(!halt_o, "R1 disabled after reset", halt_o, 0);

    // R2 instruction address halt; control 0x205 = en|addr_en|act 1
    wr(0, 1, 32'h100);
    wr(0, 0, 32'h205);
    ib(32'h104, 1);
    chk(!halt_o, "R2 address mismatch", halt_o, 0);
    ib(32'h100, 0);
    chk(!halt_o, "R6 invalid transfer", halt_o, 0);
    ib(32'h100, 1);
    chk(halt_o, "R2 address hit", halt_o, 1);
    idle(); cyc(); cyc();
    chk(halt_o, "R7 held without ack", halt_o, 1);
    // ack together with a new halt match: stays
    idle(); halt_ack_i = 1; ibus_valid_i = 1; ibus_addr_i = 32'h100; cyc(); idle();
    chk(halt_o, "R7 match wins over ack", halt_o, 1);
    ack();
    chk(!halt_o, "R7 cleared by ack", halt_o, 0);

    // R4 data-side bits on an instruction trigger have no effect
    wr(0, 3, 32'hdead);
    wr(0, 0, 32'h205 | 32'h10 | 32'h80 | 32'h20);
    ib(32'h100, 1);
    chk(halt_o, "R4 ignores data/write bits", halt_o, 1);
    ack();
    wr(0, 0, 32'h0);

    // R3 write to address, trace start; 0x487
    wr(1, 1, 32'h2000);
    wr(1, 0, 32'h487);
    db(32'h2000, 0, 0);
    chk(!trace_start_o, "R3 read rejected", trace_start_o, 0);
    db(32'h2004, 0, 1);
    chk(!trace_start_o, "R3 address rejected", trace_start_o, 0);
    ib(32'h2000, 1);
    chk(!trace_start_o, "R3 other bus ignored", trace_start_o, 0);
    db(32'h2000, 0, 1);
    chk(trace_start_o, "R8 start pulse", trace_start_o, 1);
    cyc();
    chk(!trace_start_o, "R8 pulse one cycle", trace_start_o, 0);
    wr(1, 3, 32'h55);
    wr(1, 0, 32'h497);
    db(32'h2000, 32'h54, 1);
    chk(!trace_start_o, "R3 data rejected", trace_start_o, 0);
    db(32'h2000, 32'h55, 1);
    chk(trace_start_o, "R3 all qualifiers hold", trace_start_o, 1);
    // read-only qualifier 0x447
    wr(1, 0, 32'h447);
    db(32'h2000, 0, 1);
    chk(!trace_start_o, "R3 write rejected by read-only", trace_start_o, 0);
    db(32'h2000, 0, 0);
    chk(trace_start_o, "R3 read accepted", trace_start_o, 1);

    // R5 address range with trace stop; 0x60F
    wr(1, 1, 32'h10);
    wr(1, 2, 32'h1f);
    wr(1, 0, 32'h60f);
    db(32'h0f, 0, 0);
    chk(!trace_stop_o, "R5 below low bound", trace_stop_o, 0);
    db(32'h10, 0, 0);
    chk(trace_stop_o, "R5 low bound inclusive", trace_stop_o, 1);
    db(32'h1f, 0, 1);
    chk(trace_stop_o, "R5 high bound inclusive", trace_stop_o, 1);
    db(32'h20, 0, 1);
    chk(!trace_stop_o, "R5 above high bound", trace_stop_o, 0);
    db(32'h15, 0, 0);
    chk(trace_stop_o, "R5 inside range", trace_stop_o, 1);
    // data range; 0x633
    wr(1, 3, 32'd100);
    wr(1, 4, 32'd200);
    wr(1, 0, 32'h633);
    db(32'h0, 32'd99, 1);
    chk(!trace_stop_o, "R5 data below", trace_stop_o, 0);
    db(32'h0, 32'd100, 1);
    chk(trace_stop_o, "R5 data low bound", trace_stop_o, 1);
    db(32'h0, 32'd200, 1);
    chk(trace_stop_o, "R5 data high bound", trace_stop_o, 1);
    db(32'h0, 32'd201, 1);
    chk(!trace_stop_o, "R5 data above", trace_stop_o, 0);

    // R6 enable clear
    wr(1, 0, 32'h632);
    db(32'h0, 32'd150, 1);
    chk(!trace_stop_o, "R6 disabled trigger", trace_stop_o, 0);

    // R9 two-stage: trigger 0 arms trigger 1
    wr(1, 1, 32'h3000);
    wr(1, 0, 32'h387);
    wr(0, 1, 32'h40);
    wr(0, 0, 32'h805);
    db(32'h3000, 0, 1);
    chk(!halt_o, "R9 unarmed silent", halt_o, 0);
    idle(); ibus_valid_i = 1; ibus_addr_i = 32'h40;
    dbus_valid_i = 1; dbus_addr_i = 32'h3000; dbus_we_i = 1; cyc(); idle();
    chk(!halt_o, "R9 no fire in arming cycle", halt_o, 0);
    db(32'h3000, 0, 1);
    chk(halt_o, "R9 armed fires", halt_o, 1);
    ack();
    db(32'h3000, 0, 1);
    chk(halt_o, "R9 arm flag sticky", halt_o, 1);
    ack();
    wr(1, 0, 32'h387);
    db(32'h3000, 0, 1);
    chk(!halt_o, "R9 cleared by control write", halt_o, 0);

    // R10 offset 5 write has no effect on trigger 1
    wr(1, 5, 32'hffff_ffff);
    ib(32'h40, 1);
    db(32'h3000, 0, 1);
    chk(halt_o, "R10 unused offset harmless", halt_o, 1);
    ack();

    // R1 reset clears state
    idle();
    rst_ni = 0;
    #1;
    chk(!halt_o && !trace_start_o && !trace_stop_o, "R1 async reset", halt_o, 0);
    for (int t = 0; t < 2; t++) begin
      m_ctrl[t] = '0; m_alo[t] = '0; m_ahi[t] = '0; m_dlo[t] = '0; m_dhi[t] = '0; m_arm[t] = 0;
    end
    m_halt = 0; m_ts = 0; m_tp = 0;
    @(negedge clk);
    rst_ni = 1;
    db(32'h3000, 0, 1);
    chk(!halt_o, "R1 triggers disabled after reset", halt_o, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule